// File: doc/BRIEF.md
# Ethernet MAC Interrupt Status Registers

This block collects transmit and receive event pulses from an Ethernet MAC core and holds them in two status registers. It also keeps a per-bit enable mask for each direction and drives one active-low interrupt line.

Software clears a held flag by writing a one to that flag's bit. Writing 0xFF to a status address clears every pending event of that direction. A summary register combines three conditions into active-low bits: a pending unmasked transmit event, a pending unmasked receive event, and DMA completion. Carrier sense appears in the transmit status as a live level and is never latched.

The host uses a byte-wide register bus with an address, a read strobe and a write strobe. Reads return data combinationally while `rd_i` is high. A write takes effect at the next rising clock edge. An event strobe that is high at a clock edge sets its flag at that edge.

Top module: `mac_irq_regs`

## Requirements
- R1: After reset, both status registers and both mask registers read 0x00. The summary at address 4 reads 0x07 while `dma_done_i` is low, and `irq_no_o` is 1.
- R2: A transmit status bit at address 0 is set by a pulse on the matching `tx_evt_i` bit and stays set until cleared. Bit 7 is sent OK, bit 5 is own packet seen, bit 4 is medium shorted, bit 3 is underflow, bit 2 is collision, bit 1 is sixteenth collision and bit 0 is parity error.
- R3: A receive status bit at address 2 is set by a pulse on `rx_evt_i` bits 7, 4, 3, 2, 1 or 0 and stays set until cleared. Bits 6 and 5 never set and always read 0.
- R4: Writing a status address clears each flag whose written bit is 1 and leaves the other flags unchanged. Writing 0xFF clears all flags of that direction.
- R5: Transmit status bit 6 always equals the live `carrier_i` level. Writes do not change it, and `tx_evt_i[6]` has no effect.
- R6: The transmit mask at address 1 stores only bits 7, 5, 3, 2, 1 and 0. The receive mask at address 3 stores only bits 7, 4, 3, 2, 1 and 0. All other bits read 0.
- R7: Summary bit 0 is 0 exactly when some transmit flag and its mask bit are both 1. Medium shorted cannot raise an interrupt because it has no mask bit.
- R8: Summary bit 1 is 0 exactly when some receive flag and its mask bit are both 1. Summary bit 2 is 0 exactly while `dma_done_i` is high. Summary bits 7 to 3 read 0, and writes to address 4 are ignored.
- R9: If an event strobe and a write-one clear hit the same bit in the same cycle, the flag ends up set.
- R10: `irq_no_o` is 0 exactly while any of summary bits 2 to 0 is 0.
- R11: `rdata_o` is 0x00 while `rd_i` is low. Reads of addresses 5 to 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| tx_evt_i | input | 8 | Transmit event strobes, one per status bit |
| carrier_i | input | 1 | Live carrier sense level |
| rx_evt_i | input | 8 | Receive event strobes, one per status bit |
| dma_done_i | input | 1 | DMA completion level |
| irq_no_o | output | 1 | Interrupt, active low |

## Verification
Event strobes are applied first as all-ones bursts. This shows whether the unimplemented and live bit positions are kept apart from the latched ones. Partial clear patterns such as 0x05 and 0x80 then show whether clears are selective rather than wholesale. Single events are tried against narrow masks, both matching and not matching. This separates a masked event from an unmasked one, and it shows that the unmaskable shorted flag never interrupts. A strobe and a clear landing on the same bit in one cycle check the priority between set and clear.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] ADDR_TX_STAT = 3'd0;
  localparam logic [AW-1:0] ADDR_TX_MASK = 3'd1;
  localparam logic [AW-1:0] ADDR_RX_STAT = 3'd2;
  localparam logic [AW-1:0] ADDR_RX_MASK = 3'd3;
  localparam logic [AW-1:0] ADDR_SUMMARY = 3'd4;

  localparam int unsigned CS_BIT = 6;
  localparam logic [DW-1:0] TX_EVT_BITS  = 8'hBF;
  localparam logic [DW-1:0] TX_MASK_BITS = 8'hAF;
  localparam logic [DW-1:0] RX_EVT_BITS  = 8'h9F;
  localparam logic [DW-1:0] RX_MASK_BITS = 8'h9F;
endpackage

// File: rtl/evt_latch.sv
module evt_latch #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       stat_q[i] <= 1'b0;
        else if (set_i[i]) stat_q[i] <= 1'b1;  // set beats clear
        else if (clr_i[i]) stat_q[i] <= 1'b0;
      end
    end else begin : g_none
      assign stat_q[i] = 1'b0;
    end
  end

  assign stat_o = stat_q;

  a_r9_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i & VALID) != '0 |=> (stat_o & $past(set_i & VALID)) == $past(set_i & VALID));

  a_r4_clear_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i & ~set_i & stat_o) != '0 |=> (stat_o & $past(clr_i & ~set_i)) == '0);

  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o != '0 |=> (stat_o & $past(stat_o & ~clr_i)) == $past(stat_o & ~clr_i));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (wr_i) mask_q <= wdata_i & VALID;
  end

  assign mask_o = mask_q;

  a_r6_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> mask_o == ($past(wdata_i) & VALID));
endmodule

// File: rtl/irq_summary.sv
module irq_summary #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] tx_stat_i,
  input  logic [W-1:0] tx_mask_i,
  input  logic [W-1:0] rx_stat_i,
  input  logic [W-1:0] rx_mask_i,
  input  logic         dma_done_i,
  output logic [W-1:0] summary_o,
  output logic         irq_no_o
);
  logic tx_pend, rx_pend;

  always_comb begin
    tx_pend   = |(tx_stat_i & tx_mask_i);
    rx_pend   = |(rx_stat_i & rx_mask_i);
    summary_o = '0;
    summary_o[0] = ~tx_pend;
    summary_o[1] = ~rx_pend;
    summary_o[2] = ~dma_done_i;
  end

  assign irq_no_o = &summary_o[2:0];
endmodule

// File: rtl/mac_irq_regs.sv
module mac_irq_regs
  import mac_irq_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] tx_evt_i,
  input  logic          carrier_i,
  input  logic [DW-1:0] rx_evt_i,
  input  logic          dma_done_i,
  output logic          irq_no_o
);
  logic [DW-1:0] tx_stat, rx_stat, tx_mask, rx_mask, summary;
  logic [DW-1:0] tx_clr, rx_clr;
  logic          tx_mask_we, rx_mask_we;

  always_comb begin
    tx_clr     = (wr_i && addr_i == ADDR_TX_STAT) ? wdata_i : '0;
    rx_clr     = (wr_i && addr_i == ADDR_RX_STAT) ? wdata_i : '0;
    tx_mask_we = wr_i && addr_i == ADDR_TX_MASK;
    rx_mask_we = wr_i && addr_i == ADDR_RX_MASK;
  end

  evt_latch #(.W(DW), .VALID(TX_EVT_BITS)) u_tx_stat (
    .clk_i, .rst_ni, .set_i(tx_evt_i), .clr_i(tx_clr), .stat_o(tx_stat));

  evt_latch #(.W(DW), .VALID(RX_EVT_BITS)) u_rx_stat (
    .clk_i, .rst_ni, .set_i(rx_evt_i), .clr_i(rx_clr), .stat_o(rx_stat));

  irq_mask_reg #(.W(DW), .VALID(TX_MASK_BITS)) u_tx_mask (
    .clk_i, .rst_ni, .wr_i(tx_mask_we), .wdata_i, .mask_o(tx_mask));

  irq_mask_reg #(.W(DW), .VALID(RX_MASK_BITS)) u_rx_mask (
    .clk_i, .rst_ni, .wr_i(rx_mask_we), .wdata_i, .mask_o(rx_mask));

  irq_summary #(.W(DW)) u_summary (
    .tx_stat_i(tx_stat), .tx_mask_i(tx_mask),
    .rx_stat_i(rx_stat), .rx_mask_i(rx_mask),
    .dma_done_i, .summary_o(summary), .irq_no_o);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        ADDR_TX_STAT: begin
          rdata_o = tx_stat;
          rdata_o[CS_BIT] = carrier_i;  // live level, never latched
        end
        ADDR_TX_MASK: rdata_o = tx_mask;
        ADDR_RX_STAT: rdata_o = rx_stat;
        ADDR_RX_MASK: rdata_o = rx_mask;
        ADDR_SUMMARY: rdata_o = summary;
        default:      rdata_o = '0;
      endcase
    end
  end

  a_r10_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_no_o == (((tx_stat & tx_mask) != '0) || ((rx_stat & rx_mask) != '0) || dma_done_i));

  a_r5_carrier: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == ADDR_TX_STAT) |-> rdata_o[CS_BIT] == carrier_i);

  a_r11_idle_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |-> rdata_o == '0);
endmodule

// File: tb/mac_irq_regs_tb_top.sv
module mac_irq_regs_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       rd_i = 1'b0, wr_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic [7:0] tx_evt_i = '0, rx_evt_i = '0;
  logic       carrier_i = 1'b0, dma_done_i = 1'b0;
  logic       irq_no_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  mac_irq_regs dut_i (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 chk(req, rdata_o, exp);
    rd_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(posedge clk_i); #1 wr_i = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] tx, input logic [7:0] rx);
    @(negedge clk_i);
    tx_evt_i = tx; rx_evt_i = rx;
    @(posedge clk_i); #1 tx_evt_i = '0; rx_evt_i = '0;
  endtask

  task automatic irq_chk(input logic exp, input string req);
    @(negedge clk_i);
    chk(req, {7'b0, irq_no_o}, {7'b0, exp});
  endtask

  task automatic t_reset;
    rd(3'd0, 8'h00, "R1 tx stat");
    rd(3'd1, 8'h00, "R1 tx mask");
    rd(3'd2, 8'h00, "R1 rx stat");
    rd(3'd3, 8'h00, "R1 rx mask");
    rd(3'd4, 8'h07, "R1 summary");
    irq_chk(1'b1, "R1 irq");
  endtask

  task automatic t_tx_latch;
    pulse(8'hFF, 8'h00);
    rd(3'd0, 8'hBF, "R2 tx all events");
    rd(3'd0, 8'hBF, "R2 tx held");
    wr(3'd0, 8'h05);
    rd(3'd0, 8'hBA, "R4 tx partial clear");
    wr(3'd0, 8'hFF);
    rd(3'd0, 8'h00, "R4 tx clear all");
  endtask

  task automatic t_carrier;
    @(negedge clk_i) carrier_i = 1'b1;
    rd(3'd0, 8'h40, "R5 carrier live");
    wr(3'd0, 8'h40);
    rd(3'd0, 8'h40, "R5 write no effect");
    @(negedge clk_i) carrier_i = 1'b0;
    pulse(8'h40, 8'h00);
    rd(3'd0, 8'h00, "R5 strobe ignored");
  endtask

  task automatic t_rx_latch;
    pulse(8'h00, 8'hFF);
    rd(3'd2, 8'h9F, "R3 rx all events");
    wr(3'd2, 8'h80);
    rd(3'd2, 8'h1F, "R4 rx partial clear");
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h00, "R4 rx clear all");
  endtask

  task automatic t_masks;
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'hAF, "R6 tx mask bits");
    wr(3'd3, 8'hFF);
    rd(3'd3, 8'h9F, "R6 rx mask bits");
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h07, "R8 summary write ignored");
    wr(3'd1, 8'h00);
    wr(3'd3, 8'h00);
    rd(3'd1, 8'h00, "R6 tx mask cleared");
  endtask

  task automatic t_irq_tx;
    wr(3'd1, 8'hFF);
    pulse(8'h10, 8'h00);
    rd(3'd4, 8'h07, "R7 shorted never interrupts");
    irq_chk(1'b1, "R10 irq idle");
    wr(3'd1, 8'h80);
    pulse(8'h04, 8'h00);
    rd(3'd4, 8'h07, "R7 masked collision");
    pulse(8'h80, 8'h00);
    rd(3'd4, 8'h06, "R7 unmasked sent ok");
    irq_chk(1'b0, "R10 irq tx");
    wr(3'd0, 8'h80);
    rd(3'd4, 8'h07, "R7 cleared");
    irq_chk(1'b1, "R10 irq released");
    wr(3'd0, 8'hFF);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_irq_rx;
    wr(3'd3, 8'h10);
    pulse(8'h00, 8'h02);
    rd(3'd4, 8'h07, "R8 masked crc");
    pulse(8'h00, 8'h10);
    rd(3'd4, 8'h05, "R8 unmasked reset pkt");
    irq_chk(1'b0, "R10 irq rx");
    wr(3'd2, 8'hFF);
    rd(3'd4, 8'h07, "R8 rx cleared");
    wr(3'd3, 8'h00);
  endtask

  task automatic t_dma;
    @(negedge clk_i) dma_done_i = 1'b1;
    rd(3'd4, 8'h03, "R8 dma done");
    irq_chk(1'b0, "R10 irq dma");
    @(negedge clk_i) dma_done_i = 1'b0;
    rd(3'd4, 8'h07, "R8 dma idle");
    irq_chk(1'b1, "R10 irq none");
  endtask

  task automatic t_set_wins;
    @(negedge clk_i);
    addr_i = 3'd0; wdata_i = 8'h81; wr_i = 1'b1; tx_evt_i = 8'h80;
    @(posedge clk_i); #1 wr_i = 1'b0; tx_evt_i = '0;
    rd(3'd0, 8'h80, "R9 tx set wins");
    @(negedge clk_i);
    addr_i = 3'd2; wdata_i = 8'hFF; wr_i = 1'b1; rx_evt_i = 8'h08;
    @(posedge clk_i); #1 wr_i = 1'b0; rx_evt_i = '0;
    rd(3'd2, 8'h08, "R9 rx set wins");
    wr(3'd0, 8'hFF);
    wr(3'd2, 8'hFF);
  endtask

  task automatic t_read_gate;
    pulse(8'h80, 8'h00);
    @(negedge clk_i);
    addr_i = 3'd0; rd_i = 1'b0;
    #1 chk("R11 no strobe", rdata_o, 8'h00);
    rd(3'd5, 8'h00, "R11 addr5");
    rd(3'd7, 8'h00, "R11 addr7");
    wr(3'd0, 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    t_reset();
    t_tx_latch();
    t_carrier();
    t_rx_latch();
    t_masks();
    t_irq_tx();
    t_irq_rx();
    t_dma();
    t_set_wins();
    t_read_gate();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=hung exp=done");
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule